// File: doc/BRIEF.md
# ISA Bus Slave Address Decoder

This block decides, cycle by cycle, whether a peripheral should answer the current cycle on an ISA-style asynchronous bus. It has two decode windows that are checked side by side. The first is a 16-byte I/O window that sits anywhere in the 64 KB port space. The second is a memory window in the 1 MB memory space. Each window has its own set of conditions. The outputs are a select for each window, a read/write flag and the byte offset inside the window that was hit. The register file and the data bus drivers that use these outputs are outside this block.

Decoding is purely combinational from the bus pins. Only the two base addresses and the memory-enable control bit are stored. They are loaded through a small synchronous configuration port, and reset leaves memory decoding turned off. All bus strobes, the qualifiers and the chip select are active high at the ports, so an active-low board signal is inverted before it reaches this block.

Top module: `bus_claim_decoder`

## Requirements
- R1: `io_sel` is 1 exactly when one of `ior`/`iow` is 1 (not both), `sa[15:4]` equals bits [15:4] of the I/O base, and no qualifier is active. `sa[19:16]` plays no part in the I/O decode.
- R2: While `io_sel` is 1, `offset` equals `sa[3:0]` zero-extended to 12 bits.
- R3: While any of `aen`, `refresh`, `test`, `sleep` or `bus_rst` is 1, both `io_sel` and `mem_sel` are 0.
- R4: `mem_sel` is 1 exactly when all of these hold: `chip_sel` is 1, one of `memr`/`memw` is 1 (not both), `ior` and `iow` are both 0, `sa[19:12]` equals bits [19:12] of the memory base, the memory-enable bit is set, and no qualifier is active.
- R5: The memory-enable bit is bit 10 of a write with `cfg_sel`=2. While that bit is clear, `mem_sel` stays 0 for any bus cycle.
- R6: While `mem_sel` is 1, `offset` equals `sa[11:0]`.
- R7: `rd_wr` is 1 for a claimed write (`iow` or `memw`) and 0 for a claimed read. When neither select is 1, both `rd_wr` and `offset` are 0.
- R8: A cycle with both strobes of one class active at once (`ior` and `iow`, or `memr` and `memw`) is not claimed by that class.
- R9: `io_sel` and `mem_sel` are never 1 at the same time.
- R10: When `cfg_we` is 1 at a rising clock edge, the word on `cfg_wdata` is stored. `cfg_sel`=0 loads the I/O base, 1 loads the memory base, 2 loads the control bit, and 3 changes nothing. The new value drives the decode from the following cycle. Reset sets both bases to 0 and clears memory enable.
- R11: The I/O decode does not depend on `chip_sel`, `memr`, `memw` or the memory-enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset |
| sa | input | 20 | Bus address |
| ior | input | 1 | I/O read strobe, active high |
| iow | input | 1 | I/O write strobe, active high |
| memr | input | 1 | Memory read strobe, active high |
| memw | input | 1 | Memory write strobe, active high |
| aen | input | 1 | Address-enable qualifier; blocks decode when 1 |
| refresh | input | 1 | Refresh qualifier; blocks decode when 1 |
| test | input | 1 | Test qualifier; blocks decode when 1 |
| sleep | input | 1 | Sleep qualifier; blocks decode when 1 |
| bus_rst | input | 1 | Bus reset qualifier; blocks decode when 1 |
| chip_sel | input | 1 | Chip select for the memory window |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Configuration target: 0 I/O base, 1 memory base, 2 control, 3 none |
| cfg_wdata | input | 20 | Configuration write data |
| io_sel | output | 1 | I/O window claimed |
| mem_sel | output | 1 | Memory window claimed |
| rd_wr | output | 1 | 1 = write, 0 = read for the claimed cycle |
| offset | output | 12 | Byte offset inside the claimed window |

## Verification
The hardest case to reach from the ports is a memory claim. It needs the chip select, exactly one memory strobe, both I/O strobes idle, all five qualifiers idle, the enable bit set and an 8-bit address match, all in the same cycle. Uniform random inputs almost never meet all of these at once. The stimulus therefore places the address inside a configured window most of the time, keeps each qualifier rarely active, and leans the I/O strobes towards idle. It also reloads the bases and the enable bit at intervals. Directed cases set up each single-condition miss, such as both strobes of a class together, each qualifier on its own, and memory enable cleared.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

    typedef enum logic [1:0] {
        CFG_IO_BASE  = 2'd0,
        CFG_MEM_BASE = 2'd1,
        CFG_BUS_CTL  = 2'd2,
        CFG_SPARE    = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic aen;
        logic refresh;
        logic test;
        logic sleep;
        logic bus_rst;
    } qual_t;

    typedef struct packed {
        logic hit;
        logic wr;
    } win_hit_t;

    function automatic logic any_qual(input qual_t q);
        return |q;
    endfunction

    function automatic logic single_strobe(input logic rd, input logic wr);
        return rd ^ wr;
    endfunction

endpackage

// File: rtl/bcd_cfg_regs.sv
module bcd_cfg_regs
    import bcd_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int IO_AW      = 16,
    parameter int CFG_W      = 20,
    parameter int MEM_EN_BIT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  cfg_sel_e          cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [IO_AW-1:0]  io_base,
    output logic [ADDR_W-1:0] mem_base,
    output logic              mem_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            io_base  <= '0;
            mem_base <= '0;
            mem_en   <= 1'b0;
        end else if (cfg_we) begin
            unique case (cfg_sel)
                CFG_IO_BASE:  io_base  <= cfg_wdata[IO_AW-1:0];
                CFG_MEM_BASE: mem_base <= cfg_wdata[ADDR_W-1:0];
                CFG_BUS_CTL:  mem_en   <= cfg_wdata[MEM_EN_BIT];
                default:      ;
            endcase
        end
    end

endmodule

// File: rtl/bcd_io_window.sv
module bcd_io_window
    import bcd_pkg::*;
#(
    parameter int IO_AW  = 16,
    parameter int IO_WIN = 4
) (
    input  logic [IO_AW-1:0]  sa_io,
    input  logic              ior,
    input  logic              iow,
    input  logic [IO_AW-1:0]  base,
    input  logic              blocked,
    output win_hit_t          hit,
    output logic [IO_WIN-1:0] win_off
);

    logic match;

    assign match = (sa_io >> IO_WIN) == (base >> IO_WIN);

    always_comb begin
        hit.hit = match && single_strobe(ior, iow) && !blocked;
        hit.wr  = hit.hit && iow;
        win_off = sa_io[IO_WIN-1:0];
    end

endmodule

// File: rtl/bcd_mem_window.sv
module bcd_mem_window
    import bcd_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int MEM_WIN = 12
) (
    input  logic [ADDR_W-1:0]  sa,
    input  logic               memr,
    input  logic               memw,
    input  logic               io_busy,
    input  logic               chip_sel,
    input  logic               mem_en,
    input  logic [ADDR_W-1:0]  base,
    input  logic               blocked,
    output win_hit_t           hit,
    output logic [MEM_WIN-1:0] win_off
);

    logic match;
    logic gate;

    assign match = (sa >> MEM_WIN) == (base >> MEM_WIN);
    assign gate  = chip_sel && mem_en && !io_busy && !blocked;

    always_comb begin
        hit.hit = gate && match && single_strobe(memr, memw);
        hit.wr  = hit.hit && memw;
        win_off = sa[MEM_WIN-1:0];
    end

endmodule

// File: rtl/bus_claim_decoder.sv
module bus_claim_decoder
    import bcd_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int IO_AW      = 16,
    parameter int IO_WIN     = 4,
    parameter int MEM_WIN    = 12,
    parameter int MEM_EN_BIT = 10,
    localparam int CFG_W     = ADDR_W,
    localparam int OFF_W     = (MEM_WIN > IO_WIN) ? MEM_WIN : IO_WIN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] sa,
    input  logic              ior,
    input  logic              iow,
    input  logic              memr,
    input  logic              memw,
    input  logic              aen,
    input  logic              refresh,
    input  logic              test,
    input  logic              sleep,
    input  logic              bus_rst,
    input  logic              chip_sel,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic              io_sel,
    output logic              mem_sel,
    output logic              rd_wr,
    output logic [OFF_W-1:0]  offset
);

    logic [IO_AW-1:0]   io_base;
    logic [ADDR_W-1:0]  mem_base;
    logic               mem_en;
    qual_t              qual;
    logic               blocked;
    win_hit_t           io_hit;
    win_hit_t           mem_hit;
    logic [IO_WIN-1:0]  io_off;
    logic [MEM_WIN-1:0] mem_off;

    assign qual    = '{aen: aen, refresh: refresh, test: test,
                       sleep: sleep, bus_rst: bus_rst};
    assign blocked = any_qual(qual);

    bcd_cfg_regs #(
        .ADDR_W(ADDR_W), .IO_AW(IO_AW), .CFG_W(CFG_W), .MEM_EN_BIT(MEM_EN_BIT)
    ) u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel_e'(cfg_sel)),
        .cfg_wdata(cfg_wdata), .io_base(io_base), .mem_base(mem_base),
        .mem_en(mem_en)
    );

    bcd_io_window #(.IO_AW(IO_AW), .IO_WIN(IO_WIN)) u_io (
        .sa_io(sa[IO_AW-1:0]), .ior(ior), .iow(iow), .base(io_base),
        .blocked(blocked), .hit(io_hit), .win_off(io_off)
    );

    bcd_mem_window #(.ADDR_W(ADDR_W), .MEM_WIN(MEM_WIN)) u_mem (
        .sa(sa), .memr(memr), .memw(memw), .io_busy(ior | iow),
        .chip_sel(chip_sel), .mem_en(mem_en), .base(mem_base),
        .blocked(blocked), .hit(mem_hit), .win_off(mem_off)
    );

    always_comb begin
        io_sel  = io_hit.hit;
        mem_sel = mem_hit.hit && !io_hit.hit;
        rd_wr   = 1'b0;
        offset  = '0;
        if (io_sel) begin
            rd_wr  = io_hit.wr;
            offset = OFF_W'(io_off);
        end else if (mem_sel) begin
            rd_wr  = mem_hit.wr;
            offset = OFF_W'(mem_off);
        end
    end

endmodule

// File: rtl/bcd_checker.sv
module bcd_checker #(
    parameter int ADDR_W     = 20,
    parameter int IO_WIN     = 4,
    parameter int MEM_WIN    = 12,
    parameter int MEM_EN_BIT = 10,
    parameter int OFF_W      = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] sa,
    input logic              ior,
    input logic              iow,
    input logic              memr,
    input logic              memw,
    input logic              aen,
    input logic              refresh,
    input logic              test,
    input logic              sleep,
    input logic              bus_rst,
    input logic              chip_sel,
    input logic              cfg_we,
    input logic [1:0]        cfg_sel,
    input logic [ADDR_W-1:0] cfg_wdata,
    input logic              io_sel,
    input logic              mem_sel,
    input logic              rd_wr,
    input logic [OFF_W-1:0]  offset
);

    p_io_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        io_sel |-> (ior ^ iow));

    p_io_offset_r2: assert property (@(posedge clk) disable iff (rst)
        io_sel |-> offset == OFF_W'(sa[IO_WIN-1:0]));

    p_qual_block_r3: assert property (@(posedge clk) disable iff (rst)
        (aen || refresh || test || sleep || bus_rst) |-> (!io_sel && !mem_sel));

    p_mem_cond_r4: assert property (@(posedge clk) disable iff (rst)
        mem_sel |-> (chip_sel && !ior && !iow && (memr ^ memw)));

    p_mem_en_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 2'd2 && !cfg_wdata[MEM_EN_BIT]) |=> !mem_sel);

    p_mem_offset_r6: assert property (@(posedge clk) disable iff (rst)
        mem_sel |-> offset == OFF_W'(sa[MEM_WIN-1:0]));

    p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (!io_sel && !mem_sel) |-> (offset == '0 && !rd_wr));

    p_wr_flag_r7: assert property (@(posedge clk) disable iff (rst)
        rd_wr |-> ((io_sel && iow) || (mem_sel && memw)));

    p_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(io_sel && mem_sel));

endmodule

bind bus_claim_decoder bcd_checker #(
    .ADDR_W(ADDR_W), .IO_WIN(IO_WIN), .MEM_WIN(MEM_WIN),
    .MEM_EN_BIT(MEM_EN_BIT), .OFF_W(OFF_W)
) u_chk (.*);

// File: tb/sim_bus_claim_decoder.sv
`timescale 1ns/1ps
module sim_bus_claim_decoder;

    logic        clk = 1'b0;
    logic        rst;
    logic [19:0] sa;
    logic        ior, iow, memr, memw;
    logic        aen, refresh, test, sleep, bus_rst;
    logic        chip_sel;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [19:0] cfg_wdata;
    logic        io_sel, mem_sel, rd_wr;
    logic [11:0] offset;

    int vectors = 0;
    int fails   = 0;

    logic [15:0] m_io_base;
    logic [19:0] m_mem_base;
    logic        m_mem_en;

    always #2 clk = ~clk;

    bus_claim_decoder u0 (
        .clk(clk), .rst(rst), .sa(sa), .ior(ior), .iow(iow), .memr(memr),
        .memw(memw), .aen(aen), .refresh(refresh), .test(test), .sleep(sleep),
        .bus_rst(bus_rst), .chip_sel(chip_sel), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .io_sel(io_sel),
        .mem_sel(mem_sel), .rd_wr(rd_wr), .offset(offset)
    );

    // expected {io_sel, mem_sel, rd_wr, offset}
    function automatic logic [14:0] expect_out();
        logic blk, io, mem, wr;
        logic [11:0] off;
        blk = aen | refresh | test | sleep | bus_rst;
        io  = !blk && (ior ^ iow) && (sa[15:4] == m_io_base[15:4]);
        mem = !blk && chip_sel && (memr ^ memw) && !ior && !iow && m_mem_en
              && (sa[19:12] == m_mem_base[19:12]);
        wr  = io ? iow : (mem ? memw : 1'b0);
        off = io ? {8'h00, sa[3:0]} : (mem ? sa[11:0] : 12'h000);
        return {io, mem, wr, off};
    endfunction

    task automatic check(input string req);
        logic [14:0] exp, act;
        exp = expect_out();
        act = {io_sel, mem_sel, rd_wr, offset};
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s sa=%05h act io/mem/wr/off=%b/%b/%b/%03h exp=%b/%b/%b/%03h",
                     req, sa, act[14], act[13], act[12], act[11:0],
                     exp[14], exp[13], exp[12], exp[11:0]);
        end
    endtask

    task automatic idle_bus();
        sa = '0; ior = 0; iow = 0; memr = 0; memw = 0;
        aen = 0; refresh = 0; test = 0; sleep = 0; bus_rst = 0; chip_sel = 0;
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [19:0] data);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = data;
        @(posedge clk);
        case (sel)
            2'd0: m_io_base  = data[15:0];
            2'd1: m_mem_base = data;
            2'd2: m_mem_en   = data[10];
            default: ;
        endcase
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic apply(input logic [19:0] a, input logic [3:0] io_mem,
                         input logic cs, input logic [4:0] q, input string req);
        @(negedge clk);
        sa = a; {ior, iow, memr, memw} = io_mem; chip_sel = cs;
        {aen, refresh, test, sleep, bus_rst} = q;
        #1 check(req);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: run did not complete, actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle_bus();
        cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
        m_io_base = 0; m_mem_base = 0; m_mem_en = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        // R10 reset state: bases 0, memory disabled
        apply(20'h00000, 4'b0000, 0, 5'b0, "R10 idle after reset");
        apply(20'h00005, 4'b1000, 0, 5'b0, "R10 io base resets to 0");
        apply(20'h00005, 4'b0010, 1, 5'b0, "R10 R5 memory disabled at reset");

        cfg_write(2'd0, 20'h00300);
        cfg_write(2'd1, 20'hD0000);
        cfg_write(2'd2, 20'h00400);

        apply(20'h0030A, 4'b1000, 0, 5'b0, "R1 R2 io read");
        apply(20'hF030F, 4'b1000, 0, 5'b0, "R1 upper address ignored for io");
        apply(20'h00310, 4'b1000, 0, 5'b0, "R1 just above io window");
        apply(20'h002FF, 4'b0100, 0, 5'b0, "R1 just below io window");
        apply(20'h00303, 4'b0100, 0, 5'b0, "R7 io write flag");
        apply(20'h00303, 4'b1100, 0, 5'b0, "R8 ior and iow together");
        apply(20'h00303, 4'b1011, 1, 5'b0, "R11 R9 io ignores cs and mem strobes");
        for (int i = 0; i < 5; i++)
            apply(20'h00301, 4'b1000, 0, 5'(1 << i), "R3 io blocked by qualifier");

        apply(20'hD0123, 4'b0010, 1, 5'b0, "R4 R6 memory read");
        apply(20'hD0FFF, 4'b0001, 1, 5'b0, "R7 R6 memory write");
        apply(20'hD0123, 4'b0011, 1, 5'b0, "R8 memr and memw together");
        apply(20'hD0123, 4'b0010, 0, 5'b0, "R4 chip select low");
        apply(20'hD1000, 4'b0010, 1, 5'b0, "R4 just above memory window");
        apply(20'hD0123, 4'b1010, 1, 5'b0, "R4 R9 io strobe active during memory");
        for (int i = 0; i < 5; i++)
            apply(20'hD0123, 4'b0001, 1, 5'(1 << i), "R3 memory blocked by qualifier");

        cfg_write(2'd3, 20'h00000);
        apply(20'hD0044, 4'b0010, 1, 5'b0, "R10 spare select changes nothing");
        cfg_write(2'd2, 20'hFFBFF);
        apply(20'hD0044, 4'b0010, 1, 5'b0, "R5 enable bit cleared");
        apply(20'h0030C, 4'b1000, 1, 5'b0, "R11 io unaffected by memory enable");

        for (int n = 0; n < 4000; n++) begin
            logic [19:0] a;
            logic [3:0]  st;
            logic [4:0]  q;
            if (n % 250 == 0) begin
                cfg_write(2'd0, 20'($urandom));
                cfg_write(2'd1, 20'($urandom));
                cfg_write(2'd2, ($urandom % 4 != 0) ? 20'h00400 : 20'h00000);
            end
            a = 20'($urandom);
            case ($urandom % 4)
                0: a[15:4]  = m_io_base[15:4];
                1, 2: a[19:12] = m_mem_base[19:12];
                default: ;
            endcase
            st = 4'($urandom);
            if ($urandom % 2 == 0) st[3:2] = 2'b00;
            q = '0;
            for (int k = 0; k < 5; k++) q[k] = ($urandom % 12 == 0);
            apply(a, st, ($urandom % 4 != 0), q, "R1 R2 R3 R4 R6 R7 R8 R9 R11 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule